// File: doc/BRIEF.md
# Control-Channel Resource Element Mapper

This block turns two sample streams into a sequence of resource-grid writes for the downlink control region. One stream carries the coded payload symbols. The other carries reference (pilot) symbols, which the block fetches by address. Each write names an OFDM symbol and a subcarrier and carries an I/Q pair scaled by a common amplitude.

A one-cycle start pulse latches the whole configuration: FFT size, first symbol and first subcarrier of the region, duration in symbols (1 to 3), aggregation level, the configuration-type flag, the resource-block offset and a table of control-element indices. The block then walks the region with the symbol as the outer loop. Inside each symbol it steps through table slots 0, D, 2D, and so on, where D is the duration, stopping before the aggregation level. For each slot it visits the 6 groups of the chosen element, and for each group it visits the 12 subcarriers. Each cycle in which the needed input is valid produces one grid write. A done pulse marks the final write.

Top module: `pdcch_re_mapper`

## Requirements
- R1: After a start pulse, writes follow this order: symbol index s from 0 to dur_i-1; within s, table slot c = 0, dur_i, 2·dur_i, … while c < agg_i; within c, group r from 0 to 5; within r, position m from 0 to 11. Entry c of the table is bits [6c+5:6c] of cce_order_i, and the group index is entry·6 + r. Exactly one write is produced per (s, c, r, m).
- R2: Positions m = 1, 5 and 9 take their sample from the reference inputs. The other nine positions take the next payload sample, in arrival order.
- R3: el_sym_o equals first_sym_i + s.
- R4: The group base is first_sc_i + group·12, reduced once by fft_size_i if it is at or above fft_size_i. The subcarrier for position m is the base plus m, again reduced by fft_size_i when it reaches or exceeds fft_size_i.
- R5: At a reference position, ref_addr_o = (group + off)·3 + m/4, where off is 0 when dedicated_i=1 and rb_off_i when dedicated_i=0.
- R6: el_re_o and el_im_o each equal bits [30:15] of amp_i (unsigned) times the selected sample (signed 16-bit). That is an arithmetic shift right by 15 with truncation and no saturation.
- R7: A cycle whose needed input is not valid (pay_valid_i for payload positions, ref_valid_i for reference positions) produces no write in the following cycle and does not advance the walk.
- R8: done_o pulses for one cycle together with the final write. After that, el_valid_o, pay_ready_o and ref_req_o stay low until the next start.
- R9: A start pulse that arrives while a walk is in progress is ignored. The walk continues with the configuration it latched.
- R10: While rst_ni is low, el_valid_o, done_o, pay_ready_o and ref_req_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a walk and latches the configuration |
| fft_size_i | input | 13 | FFT size, used as the subcarrier modulus |
| first_sym_i | input | 4 | First symbol of the region |
| first_sc_i | input | 13 | First subcarrier of the region |
| dur_i | input | 2 | Region duration in symbols (1 to 3) |
| agg_i | input | 5 | Aggregation level (1 to 16) |
| dedicated_i | input | 1 | 1: no resource-block offset on reference addresses |
| rb_off_i | input | 9 | Resource-block offset applied to reference addresses |
| cce_order_i | input | 96 | Sixteen 6-bit control-element indices; slot c is at bits [6c+5:6c] |
| amp_i | input | 16 | Amplitude, unsigned |
| pay_valid_i | input | 1 | Payload sample valid |
| pay_ready_o | output | 1 | Payload sample taken when valid |
| pay_re_i | input | 16 | Payload I |
| pay_im_i | input | 16 | Payload Q |
| ref_req_o | output | 1 | Reference sample needed at ref_addr_o |
| ref_addr_o | output | 12 | Reference sample index |
| ref_valid_i | input | 1 | Reference sample valid |
| ref_re_i | input | 16 | Reference I |
| ref_im_i | input | 16 | Reference Q |
| el_valid_o | output | 1 | Grid write valid |
| el_sym_o | output | 4 | Symbol of the write |
| el_sc_o | output | 13 | Subcarrier of the write |
| el_re_o | output | 16 | Scaled I |
| el_im_o | output | 16 | Scaled Q |
| done_o | output | 1 | Pulses with the final write |

## Verification
The bench targets several corner cases.
- A region that starts a few subcarriers below the FFT size wraps partway through a group. A mapper that wraps only at group starts, or never wraps, writes past the grid edge.
- A duration larger than the aggregation level, and durations of two and three symbols with unequal slot counts, expose a walk that steps table slots by one instead of by the duration, or that does not restart the slot counter for each symbol.
- Configurations of both types with a non-zero block offset catch a reference address that ignores the type flag.
- Full-scale amplitude with negative samples catches saturation or a logical shift.
- Periodic input stalls, and a second start pulse mid-walk, show whether the walk skips or resumes correctly and whether it holds the configuration it latched.

// File: rtl/pdcch_map_pkg.sv
package pdcch_map_pkg;
  localparam int REGS_PER_CCE = 6;
  localparam int SC_PER_RB    = 12;
  localparam int REF_PER_RB   = 3;
endpackage

// File: rtl/pdcch_amp_scale.sv
module pdcch_amp_scale #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]        amp_i,
  input  logic signed [DW-1:0] smp_i,
  output logic signed [DW-1:0] res_o
);
  localparam int PW = 2 * DW + 1;
  localparam int SH = DW - 1;

  logic signed [PW-1:0] prod;
  assign prod  = PW'($signed({1'b0, amp_i})) * PW'(smp_i);
  assign res_o = DW'(prod >>> SH);
endmodule

// File: rtl/pdcch_re_walker.sv
module pdcch_re_walker
  import pdcch_map_pkg::*;
#(
  parameter int SC_W    = 13,
  parameter int SYM_W   = 4,
  parameter int AGG_W   = 5,
  parameter int MAX_AGG = 16,
  parameter int OIDX_W  = 6,
  parameter int RBO_W   = 9,
  parameter int REF_W   = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      launch_i,
  input  logic [SC_W-1:0]           fft_i,
  input  logic [SYM_W-1:0]          ssym_i,
  input  logic [SC_W-1:0]           ssc_i,
  input  logic [1:0]                dur_i,
  input  logic [AGG_W-1:0]          agg_i,
  input  logic                      ded_i,
  input  logic [RBO_W-1:0]          rbo_i,
  input  logic [MAX_AGG*OIDX_W-1:0] order_i,
  input  logic                      step_i,
  output logic                      busy_o,
  output logic                      is_ref_o,
  output logic                      last_o,
  output logic [SYM_W-1:0]          sym_o,
  output logic [SC_W-1:0]           sc_o,
  output logic [REF_W-1:0]          ref_addr_o
);
  localparam int CNT_W  = $clog2(MAX_AGG);
  localparam int GRP_W  = OIDX_W + 3;
  localparam int WIDE_W = SC_W + 2;
  localparam int SUM_W  = AGG_W + 1;

  logic              busy_q, ded_q;
  logic [SC_W-1:0]   fft_q, ssc_q;
  logic [SYM_W-1:0]  ssym_q;
  logic [1:0]        dur_q, sym_q;
  logic [AGG_W-1:0]  agg_q, cnt_q;
  logic [RBO_W-1:0]  rbo_q;
  logic [2:0]        reg_q;
  logic [3:0]        m_q;
  logic [OIDX_W-1:0] ord_q [MAX_AGG];

  wire take = launch_i && !busy_q;

  for (genvar g = 0; g < MAX_AGG; g++) begin : g_ord
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   ord_q[g] <= '0;
      else if (take) ord_q[g] <= order_i[g*OIDX_W +: OIDX_W];
    end
  end

  logic [OIDX_W-1:0] cur_ord;
  logic [GRP_W-1:0]  grp;
  logic [WIDE_W-1:0] base_raw, base, sc_raw, sc_w;
  logic [RBO_W-1:0]  off;
  logic [SUM_W-1:0]  cnt_nxt;
  logic              m_end, reg_end, cce_end, sym_end;

  always_comb begin
    cur_ord  = ord_q[cnt_q[CNT_W-1:0]];
    grp      = GRP_W'(cur_ord) * GRP_W'(REGS_PER_CCE) + GRP_W'(reg_q);
    base_raw = WIDE_W'(ssc_q) + WIDE_W'(grp) * WIDE_W'(SC_PER_RB);
    base     = (base_raw >= WIDE_W'(fft_q)) ? base_raw - WIDE_W'(fft_q) : base_raw;
    sc_raw   = base + WIDE_W'(m_q);
    sc_w     = (sc_raw >= WIDE_W'(fft_q)) ? sc_raw - WIDE_W'(fft_q) : sc_raw;
    off      = ded_q ? '0 : rbo_q;
    cnt_nxt  = SUM_W'(cnt_q) + SUM_W'(dur_q);
    m_end    = (m_q == 4'd11);
    reg_end  = (reg_q == 3'd5);
    cce_end  = (cnt_nxt >= SUM_W'(agg_q));
    sym_end  = (sym_q == dur_q - 2'd1);
  end

  assign busy_o     = busy_q;
  assign is_ref_o   = (m_q[1:0] == 2'd1);
  assign last_o     = busy_q && m_end && reg_end && cce_end && sym_end;
  assign sym_o      = ssym_q + SYM_W'(sym_q);
  assign sc_o       = SC_W'(sc_w);
  assign ref_addr_o = REF_W'((REF_W'(grp) + REF_W'(off)) * REF_W'(REF_PER_RB) + REF_W'(m_q[3:2]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; ded_q <= 1'b0; fft_q <= '0; ssc_q <= '0; ssym_q <= '0;
      dur_q <= 2'd1; agg_q <= '0; rbo_q <= '0;
      sym_q <= '0; cnt_q <= '0; reg_q <= '0; m_q <= '0;
    end else if (take) begin
      busy_q <= 1'b1; ded_q <= ded_i; fft_q <= fft_i; ssc_q <= ssc_i; ssym_q <= ssym_i;
      dur_q <= dur_i; agg_q <= agg_i; rbo_q <= rbo_i;
      sym_q <= '0; cnt_q <= '0; reg_q <= '0; m_q <= '0;
    end else if (busy_q && step_i) begin
      if (!m_end) m_q <= m_q + 4'd1;
      else begin
        m_q <= '0;
        if (!reg_end) reg_q <= reg_q + 3'd1;
        else begin
          reg_q <= '0;
          if (!cce_end) cnt_q <= AGG_W'(cnt_nxt);
          else begin
            cnt_q <= '0;
            if (sym_end) busy_q <= 1'b0;
            else         sym_q  <= sym_q + 2'd1;
          end
        end
      end
    end
  end

  // R4: subcarrier never leaves the grid
  p_sc_in_grid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (sc_o < fft_q));
  // R3: symbol address holds or moves up by one
  p_sym_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && step_i && !last_o) |=> (sym_o == $past(sym_o)) || (sym_o == $past(sym_o) + SYM_W'(1)));
  // R9: latched configuration survives a start during a walk
  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && launch_i) |=> $stable(fft_q) && $stable(agg_q) && $stable(ssc_q) && $stable(dur_q));
endmodule

// File: rtl/pdcch_re_mapper.sv
module pdcch_re_mapper #(
  parameter int SC_W    = 13,
  parameter int SYM_W   = 4,
  parameter int AGG_W   = 5,
  parameter int MAX_AGG = 16,
  parameter int OIDX_W  = 6,
  parameter int RBO_W   = 9,
  parameter int REF_W   = 12,
  parameter int DW      = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [SC_W-1:0]           fft_size_i,
  input  logic [SYM_W-1:0]          first_sym_i,
  input  logic [SC_W-1:0]           first_sc_i,
  input  logic [1:0]                dur_i,
  input  logic [AGG_W-1:0]          agg_i,
  input  logic                      dedicated_i,
  input  logic [RBO_W-1:0]          rb_off_i,
  input  logic [MAX_AGG*OIDX_W-1:0] cce_order_i,
  input  logic [DW-1:0]             amp_i,
  input  logic                      pay_valid_i,
  output logic                      pay_ready_o,
  input  logic [DW-1:0]             pay_re_i,
  input  logic [DW-1:0]             pay_im_i,
  output logic                      ref_req_o,
  output logic [REF_W-1:0]          ref_addr_o,
  input  logic                      ref_valid_i,
  input  logic [DW-1:0]             ref_re_i,
  input  logic [DW-1:0]             ref_im_i,
  output logic                      el_valid_o,
  output logic [SYM_W-1:0]          el_sym_o,
  output logic [SC_W-1:0]           el_sc_o,
  output logic [DW-1:0]             el_re_o,
  output logic [DW-1:0]             el_im_o,
  output logic                      done_o
);
  logic             busy, is_ref, last, step;
  logic [SYM_W-1:0] sym;
  logic [SC_W-1:0]  sc;

  pdcch_re_walker #(
    .SC_W(SC_W), .SYM_W(SYM_W), .AGG_W(AGG_W), .MAX_AGG(MAX_AGG),
    .OIDX_W(OIDX_W), .RBO_W(RBO_W), .REF_W(REF_W)
  ) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(start_i),
    .fft_i(fft_size_i), .ssym_i(first_sym_i), .ssc_i(first_sc_i),
    .dur_i(dur_i), .agg_i(agg_i), .ded_i(dedicated_i), .rbo_i(rb_off_i),
    .order_i(cce_order_i), .step_i(step),
    .busy_o(busy), .is_ref_o(is_ref), .last_o(last),
    .sym_o(sym), .sc_o(sc), .ref_addr_o(ref_addr_o)
  );

  assign pay_ready_o = busy && !is_ref;
  assign ref_req_o   = busy && is_ref;
  assign step        = busy && (is_ref ? ref_valid_i : pay_valid_i);

  logic signed [DW-1:0] smp [2];
  logic signed [DW-1:0] scl [2];
  assign smp[0] = is_ref ? ref_re_i : pay_re_i;
  assign smp[1] = is_ref ? ref_im_i : pay_im_i;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    pdcch_amp_scale #(.DW(DW)) u_scl (.amp_i(amp_i), .smp_i(smp[l]), .res_o(scl[l]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      el_valid_o <= 1'b0; done_o <= 1'b0;
      el_sym_o <= '0; el_sc_o <= '0; el_re_o <= '0; el_im_o <= '0;
    end else begin
      el_valid_o <= step;
      done_o     <= step && last;
      if (step) begin
        el_sym_o <= sym;
        el_sc_o  <= sc;
        el_re_o  <= scl[0];
        el_im_o  <= scl[1];
      end
    end
  end

  // R8: done only accompanies a write
  p_done_with_el_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> el_valid_o);
  // R7: a starved request yields no write
  p_no_write_on_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ref_req_o && !ref_valid_i) || (pay_ready_o && !pay_valid_i)) |=> !el_valid_o);
  // R2: reference and payload are never requested together
  p_one_source_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pay_ready_o, ref_req_o}));
endmodule

// File: tb/sim_pdcch_re_mapper.sv
module sim_pdcch_re_mapper;
  typedef struct packed {
    logic [12:0] fft; logic [3:0] ssym; logic [12:0] ssc; logic [1:0] dur;
    logic [4:0] agg; logic ded; logic [8:0] rbo; logic [15:0] amp; logic stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{13'd2048, 4'd0, 13'd0,    2'd1, 5'd4,  1'b1, 9'd0,   16'd16384, 1'b0},
    '{13'd768,  4'd2, 13'd700,  2'd2, 5'd4,  1'b0, 9'd5,   16'd32767, 1'b0},
    '{13'd4096, 4'd1, 13'd4090, 2'd3, 5'd8,  1'b0, 9'd100, 16'd40000, 1'b1},
    '{13'd1024, 4'd5, 13'd100,  2'd2, 5'd1,  1'b1, 9'd7,   16'd1,     1'b0},
    '{13'd2048, 4'd0, 13'd12,   2'd1, 5'd16, 1'b0, 9'd3,   16'd65535, 1'b1},
    '{13'd512,  4'd3, 13'd400,  2'd3, 5'd2,  1'b1, 9'd0,   16'd12345, 1'b0}
  };
  localparam int MAXE = 1200;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [12:0] fft_size_i = '0, first_sc_i = '0;
  logic [3:0]  first_sym_i = '0;
  logic [1:0]  dur_i = 2'd1;
  logic [4:0]  agg_i = 5'd1;
  logic        dedicated_i = 1'b0;
  logic [8:0]  rb_off_i = '0;
  logic [95:0] cce_order_i = '0;
  logic [15:0] amp_i = '0;
  logic pay_valid_i, pay_ready_o, ref_req_o, ref_valid_i, el_valid_o, done_o;
  logic [15:0] pay_re_i, pay_im_i, ref_re_i, ref_im_i, el_re_o, el_im_o;
  logic [11:0] ref_addr_o;
  logic [3:0]  el_sym_o;
  logic [12:0] el_sc_o;

  int nchk = 0, nerr = 0, cyc = 0, pay_cnt = 0;
  logic stall_en = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [15:0] f_pre(input int n); return 16'(n * 1103 + 7); endfunction
  function automatic logic [15:0] f_pim(input int n); return 16'(~(n * 577)); endfunction
  function automatic logic [15:0] f_rre(input int a); return 16'(a * 2749 + 1); endfunction
  function automatic logic [15:0] f_rim(input int a); return 16'(a * 911 + 45000); endfunction
  function automatic logic [15:0] f_scl(input logic [15:0] a, input logic [15:0] x);
    logic signed [32:0] p;
    p = $signed({17'd0, a}) * $signed({{17{x[15]}}, x});
    return p[30:15];
  endfunction

  assign pay_valid_i = !(stall_en && (cyc % 3 == 0));
  assign ref_valid_i = pay_valid_i;
  assign pay_re_i = f_pre(pay_cnt);
  assign pay_im_i = f_pim(pay_cnt);
  assign ref_re_i = f_rre(int'(ref_addr_o));
  assign ref_im_i = f_rim(int'(ref_addr_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pay_valid_i && pay_ready_o) pay_cnt <= pay_cnt + 1;
  end

  pdcch_re_mapper u0 (.*, .clk_i(clk));

  logic [3:0]  e_sym [MAXE];
  logic [12:0] e_sc  [MAXE];
  logic [15:0] e_re  [MAXE];
  logic [15:0] e_im  [MAXE];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // independent model of the walk; returns element count
  task automatic build(input int v, input int pbase, output int total);
    vec_t c = VECS[v];
    int n = 0, pn = 0;
    for (int s = 0; s < int'(c.dur); s++)
      for (int cc = 0; cc < int'(c.agg); cc += int'(c.dur)) begin
        int o = (cc * 5 + v * 3) % 8;
        for (int r = 0; r < 6; r++) begin
          int grp = o * 6 + r;
          int k = int'(c.ssc) + grp * 12;
          if (k >= int'(c.fft)) k -= int'(c.fft);
          for (int m = 0; m < 12; m++) begin
            logic [15:0] xr, xi;
            if (m % 4 == 1) begin
              int a = (grp + (c.ded ? 0 : int'(c.rbo))) * 3 + m / 4;
              xr = f_rre(a); xi = f_rim(a);
            end else begin
              xr = f_pre(pbase + pn); xi = f_pim(pbase + pn); pn++;
            end
            e_sym[n] = 4'(int'(c.ssym) + s);
            e_sc[n]  = 13'(k);
            e_re[n]  = f_scl(c.amp, xr);
            e_im[n]  = f_scl(c.amp, xi);
            n++;
            k++;
            if (k >= int'(c.fft)) k -= int'(c.fft);
          end
        end
      end
    total = n;
  endtask

  task automatic run_vec(input int v, input bit mid);
    vec_t c = VECS[v];
    int total, got = 0, to = 0;
    bit done_seen = 0, mid_done = 0, prev_stall = 0;
    string tag = mid ? "R9/R1/R2/R3/R4/R5/R6" : "R1/R2/R3/R4/R5/R6";
    for (int i = 0; i < 16; i++) cce_order_i[i*6 +: 6] = 6'((i * 5 + v * 3) % 8);
    build(v, pay_cnt, total);
    fft_size_i = c.fft; first_sym_i = c.ssym; first_sc_i = c.ssc; dur_i = c.dur;
    agg_i = c.agg; dedicated_i = c.ded; rb_off_i = c.rbo; amp_i = c.amp; stall_en = c.stall;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_seen && to < 20000) begin
      if (el_valid_o) begin
        if (got < total)
          chk({el_sym_o, el_sc_o, el_re_o, el_im_o} == {e_sym[got], e_sc[got], e_re[got], e_im[got]},
              tag, $sformatf("vec %0d element %0d {sym,sc,re,im}", v, got),
              {el_sym_o, el_sc_o, el_re_o, el_im_o}, {e_sym[got], e_sc[got], e_re[got], e_im[got]});
        else chk(0, "R1", "extra element", got, total);
        got++;
      end
      if (c.stall && prev_stall && el_valid_o) chk(0, "R7", "write after stalled cycle", 1, 0);
      prev_stall = stall_en && (cyc % 3 == 0);
      if (done_o) begin
        chk(got == total, "R8", $sformatf("vec %0d count at done", v), got, total);
        done_seen = 1;
      end
      if (mid && got == 50 && !mid_done) begin
        start_i = 1'b1; fft_size_i = 13'd100; agg_i = 5'd2; first_sc_i = 13'd7; dur_i = 2'd1;
        mid_done = 1;
      end else start_i = 1'b0;
      if (!done_seen) begin @(negedge clk); to++; end
    end
    start_i = 1'b0;
    if (!done_seen) chk(0, "R8", $sformatf("vec %0d watchdog, no done", v), got, total);
    @(negedge clk);
    chk(!el_valid_o && !done_o && !pay_ready_o && !ref_req_o, "R8",
        $sformatf("vec %0d idle after done {valid,done,pready,rreq}", v),
        {el_valid_o, done_o, pay_ready_o, ref_req_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!el_valid_o && !done_o && !pay_ready_o && !ref_req_o, "R10",
        "reset outputs {valid,done,pready,rreq}",
        {el_valid_o, done_o, pay_ready_o, ref_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!el_valid_o && !pay_ready_o && !ref_req_o, "R10", "idle after reset",
        {el_valid_o, pay_ready_o, ref_req_o}, 0);
    for (int v = 0; v < NV; v++) run_vec(v, v == 2);
    // R9: a second walk after an ignored mid-walk start still runs correctly
    run_vec(1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nchk++; nerr++;
    $display("FAIL R8 global watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule